// File: doc/BRIEF.md
# Shared Packet Bus Arbiter

This block controls one board's side of a single packet bus that several boards share. A strap input sets the board's role. The one master board holds a busy line and has a separate request/grant pair for each slave board. It either hands the bus to a slave or sends its own queued packets. A slave raises its request and waits for its grant. It then drives its queued packets, each tagged with a destination board number, and drops the request once its queue is empty.

Tri-state ownership is modelled with a drive-enable output next to a separate outgoing and incoming data word. The outgoing word is zero whenever the board is not driving. Every board watches the incoming word and accepts only valid packets addressed to its own board number.

Bus word layout (114 bits with the defaults):
- Bit 113: valid flag.
- Bits 112:105: destination board number.
- Bits 104:0: payload.

Top module: `pkt_bus_arbiter`

## Requirements
- R1: After reset `busy_o`, `gnt_o`, `req_o`, `bus_oe_o`, `tx_pop_o` and `rx_valid_o` are all low.
- R2: A master that is idle grants a requesting slave in the clock cycle after it samples the request. It raises exactly that slave's `gnt_o` bit and `busy_o` together.
- R3: A slave with queued packets raises `req_o`. It drives the bus (`bus_oe_o`) only from the cycle after it samples `gnt_i` high, and drives nothing before that.
- R4: A grant and `busy_o` stay high for as long as the granted slave holds its request. Both drop in the cycle after the master samples the request low.
- R5: The master chooses among several pending requests by rotating priority. After serving slave k, the search starts at slave k+1 and wraps from the last slave to slave 0.
- R6: The master sends its own packets only when it is idle and no slave request is pending. While sending, it holds `busy_o` high and puts out one valid word per queued packet (`tx_pop_o` per word). A request that arrives meanwhile is granted only after the master's queue has drained.
- R7: The two sides never drive at the same time. The master never drives while a grant is high, and its drive never starts in the cycle right after a grant was high.
- R8: A slave lowers `req_o` and `bus_oe_o` on the same edge, one cycle after its queue runs empty.
- R9: `rx_valid_o` is high only when the incoming word has its valid bit set, carries this board's number, and this board is not driving. `rx_pay_o` then carries that word's payload.
- R10: In slave mode `gnt_o` and `busy_o` stay low whatever arrives on `req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| is_master_i | input | 1 | Role strap: 1 = master, 0 = slave |
| board_id_i | input | 8 | This board's number |
| tx_pending_i | input | 1 | Local transmit queue not empty |
| tx_dst_i | input | 8 | Destination of the queue head |
| tx_pay_i | input | 105 | Payload of the queue head |
| tx_pop_o | output | 1 | Queue head sent this cycle |
| bus_data_i | input | 114 | Word seen on the shared bus |
| bus_data_o | output | 114 | Word driven on the shared bus |
| bus_oe_o | output | 1 | Drive enable for the shared bus |
| busy_o | output | 1 | Busy line, driven by the master |
| req_i | input | 3 | Requests from the slaves (master side) |
| gnt_o | output | 3 | Grants to the slaves (master side) |
| req_o | output | 1 | This slave's request |
| gnt_i | input | 1 | This slave's grant |
| rx_valid_o | output | 1 | Packet for this board on the bus |
| rx_pay_o | output | 105 | Payload of the received packet |

## Verification
On every cycle the assertions check these relations:
- Grants are one-hot or zero and always come with busy.
- A grant holds while its request is high and releases the cycle after the request falls.
- The master never drives while a grant is up, or just after one.
- A slave drives only under its grant and drops request and drive together.
- A slave-mode board keeps its master outputs quiet.

Only the bench scenarios can show the rest:
- The order in which grants rotate among three simultaneous requests.
- That the master's own words come out complete and in queue order, only after a slave finishes.
- That a request raised during a master transfer waits for the transfer to end.
- That the receive filter separates matching, foreign, invalid and self-driven words.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int ID_W  = 8;
  localparam int PAY_W = 105;
  localparam int BUS_W = 1 + ID_W + PAY_W;

  typedef struct packed {
    logic             vld;
    logic [ID_W-1:0]  dst;
    logic [PAY_W-1:0] pay;
  } bus_word_t;

  typedef enum logic [1:0] {M_IDLE, M_GRANT, M_SEND} mst_state_e;
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_XFER} slv_state_e;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N     = 3,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  // first request at or after ptr_i, wrapping
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < N; k++) begin
      if (!found_o && req_i[(int'(ptr_i) + k) % N]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'((int'(ptr_i) + k) % N);
      end
    end
  end
endmodule

// File: rtl/master_ctl.sv
module master_ctl
  import arb_pkg::*;
#(
  parameter int N_SLAVES = 3,
  localparam int IDX_W = (N_SLAVES > 1) ? $clog2(N_SLAVES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [N_SLAVES-1:0] req_i,
  input  logic                tx_pending_i,
  output logic                drive_o,
  output logic                send_o,
  output logic                busy_o,
  output logic [N_SLAVES-1:0] gnt_o
);
  mst_state_e          state_q;
  logic [N_SLAVES-1:0] gnt_q;
  logic                busy_q;
  logic [IDX_W-1:0]    cur_q, ptr_q;
  logic                pick_found;
  logic [IDX_W-1:0]    pick_idx;
  logic [IDX_W-1:0]    ptr_next;

  rr_pick #(.N(N_SLAVES), .IDX_W(IDX_W)) u_pick (
    .req_i  (req_i),
    .ptr_i  (ptr_q),
    .found_o(pick_found),
    .idx_o  (pick_idx)
  );

  assign ptr_next = (pick_idx == IDX_W'(N_SLAVES - 1)) ? '0 : pick_idx + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= M_IDLE;
      gnt_q   <= '0;
      busy_q  <= 1'b0;
      cur_q   <= '0;
      ptr_q   <= '0;
    end else if (!en_i) begin
      state_q <= M_IDLE;
      gnt_q   <= '0;
      busy_q  <= 1'b0;
      cur_q   <= '0;
      ptr_q   <= '0;
    end else begin
      case (state_q)
        M_IDLE: begin
          // slave requests take precedence over local traffic
          if (pick_found) begin
            state_q <= M_GRANT;
            gnt_q   <= N_SLAVES'(1) << pick_idx;
            busy_q  <= 1'b1;
            cur_q   <= pick_idx;
            ptr_q   <= ptr_next;
          end else if (tx_pending_i) begin
            state_q <= M_SEND;
            busy_q  <= 1'b1;
          end
        end
        M_GRANT: begin
          if (!req_i[cur_q]) begin
            state_q <= M_IDLE;
            gnt_q   <= '0;
            busy_q  <= 1'b0;
          end
        end
        M_SEND: begin
          if (!tx_pending_i) begin
            state_q <= M_IDLE;
            busy_q  <= 1'b0;
          end
        end
        default: state_q <= M_IDLE;
      endcase
    end
  end

  assign drive_o = (state_q == M_SEND);
  assign send_o  = drive_o && tx_pending_i;
  assign busy_o  = busy_q;
  assign gnt_o   = gnt_q;
endmodule

// File: rtl/slave_ctl.sv
module slave_ctl
  import arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tx_pending_i,
  input  logic gnt_i,
  output logic req_o,
  output logic drive_o,
  output logic send_o
);
  slv_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
    end else if (!en_i) begin
      state_q <= S_IDLE;
    end else begin
      case (state_q)
        S_IDLE:  if (tx_pending_i)  state_q <= S_REQ;
        S_REQ:   if (gnt_i)         state_q <= S_XFER;
        S_XFER:  if (!tx_pending_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // request and drive fall on the same edge
  assign req_o   = (state_q != S_IDLE);
  assign drive_o = (state_q == S_XFER);
  assign send_o  = drive_o && tx_pending_i;
endmodule

// File: rtl/rx_filter.sv
module rx_filter
  import arb_pkg::*;
(
  input  logic [BUS_W-1:0] bus_data_i,
  input  logic             own_drive_i,
  input  logic [ID_W-1:0]  board_id_i,
  output logic             rx_valid_o,
  output logic [PAY_W-1:0] rx_pay_o
);
  bus_word_t w;
  assign w          = bus_word_t'(bus_data_i);
  assign rx_valid_o = !own_drive_i && w.vld && (w.dst == board_id_i);
  assign rx_pay_o   = w.pay;
endmodule

// File: rtl/pkt_bus_arbiter.sv
module pkt_bus_arbiter
  import arb_pkg::*;
#(
  parameter int N_SLAVES = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                is_master_i,
  input  logic [ID_W-1:0]     board_id_i,
  input  logic                tx_pending_i,
  input  logic [ID_W-1:0]     tx_dst_i,
  input  logic [PAY_W-1:0]    tx_pay_i,
  output logic                tx_pop_o,
  input  logic [BUS_W-1:0]    bus_data_i,
  output logic [BUS_W-1:0]    bus_data_o,
  output logic                bus_oe_o,
  output logic                busy_o,
  input  logic [N_SLAVES-1:0] req_i,
  output logic [N_SLAVES-1:0] gnt_o,
  output logic                req_o,
  input  logic                gnt_i,
  output logic                rx_valid_o,
  output logic [PAY_W-1:0]    rx_pay_o
);
  logic m_drive, m_send, s_drive, s_send, s_req;
  logic drive, send;
  bus_word_t tx_word;

  master_ctl #(.N_SLAVES(N_SLAVES)) u_mst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (is_master_i),
    .req_i       (req_i),
    .tx_pending_i(tx_pending_i),
    .drive_o     (m_drive),
    .send_o      (m_send),
    .busy_o      (busy_o),
    .gnt_o       (gnt_o)
  );

  slave_ctl u_slv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (!is_master_i),
    .tx_pending_i(tx_pending_i),
    .gnt_i       (gnt_i),
    .req_o       (s_req),
    .drive_o     (s_drive),
    .send_o      (s_send)
  );

  assign drive = is_master_i ? m_drive : s_drive;
  assign send  = is_master_i ? m_send  : s_send;
  assign req_o = s_req;

  assign tx_word.vld = send;
  assign tx_word.dst = tx_dst_i;
  assign tx_word.pay = tx_pay_i;

  assign bus_oe_o   = drive;
  assign bus_data_o = drive ? BUS_W'(tx_word) : '0;
  assign tx_pop_o   = send;

  rx_filter u_rx (
    .bus_data_i (bus_data_i),
    .own_drive_i(drive),
    .board_id_i (board_id_i),
    .rx_valid_o (rx_valid_o),
    .rx_pay_o   (rx_pay_o)
  );
endmodule

// File: rtl/pkt_bus_arbiter_chk.sv
module pkt_bus_arbiter_chk #(
  parameter int N_SLAVES = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                is_master_i,
  input logic                bus_oe_o,
  input logic                busy_o,
  input logic [N_SLAVES-1:0] req_i,
  input logic [N_SLAVES-1:0] gnt_o,
  input logic                req_o,
  input logic                gnt_i,
  input logic                rx_valid_o
);
  a_r2_grant_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0) |-> busy_o);

  a_r4_onehot_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  a_r4_hold_tenure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_master_i && ((gnt_o & req_i) != '0)) |=> (gnt_o == $past(gnt_o)));

  a_r4_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_master_i && (gnt_o != '0) && ((gnt_o & req_i) == '0)) |=> (gnt_o == '0 && !busy_o));

  a_r7_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_master_i && bus_oe_o) |-> (gnt_o == '0));

  a_r7_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_master_i && $rose(bus_oe_o)) |-> ($past(gnt_o) == '0));

  a_r6_send_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_master_i && bus_oe_o) |-> busy_o);

  a_r3_drive_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_master_i && bus_oe_o) |-> gnt_i);

  a_r8_release_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_master_i && $fell(req_o)) |-> !bus_oe_o);

  a_r9_no_self_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> !rx_valid_o);

  a_r10_slave_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_master_i |-> (gnt_o == '0 && !busy_o));
endmodule

bind pkt_bus_arbiter pkt_bus_arbiter_chk #(.N_SLAVES(N_SLAVES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .is_master_i(is_master_i),
  .bus_oe_o   (bus_oe_o),
  .busy_o     (busy_o),
  .req_i      (req_i),
  .gnt_o      (gnt_o),
  .req_o      (req_o),
  .gnt_i      (gnt_i),
  .rx_valid_o (rx_valid_o)
);

// File: tb/pkt_bus_arbiter_test.sv
module pkt_bus_arbiter_test;
  import arb_pkg::*;
  localparam int N = 3;
  localparam logic [ID_W-1:0] MY_ID = 8'h05;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic is_master_i = 1'b1;
  logic tx_pending_i = 1'b0;
  logic [ID_W-1:0] tx_dst_i = '0;
  logic [PAY_W-1:0] tx_pay_i = '0;
  logic tx_pop_o;
  logic [BUS_W-1:0] bus_data_i = '0;
  logic [BUS_W-1:0] bus_data_o;
  logic bus_oe_o, busy_o, req_o, rx_valid_o;
  logic [N-1:0] req_i = '0;
  logic [N-1:0] gnt_o;
  logic gnt_i = 1'b0;
  logic [PAY_W-1:0] rx_pay_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string mon_tag = "R6";

  logic [BUS_W-1:0] tx_q[$];
  logic [BUS_W-1:0] exp_bus[$];
  int exp_gnt[$];
  logic [N-1:0] gnt_prev = '0;

  always #10 clk = ~clk;

  pkt_bus_arbiter #(.N_SLAVES(N)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .is_master_i(is_master_i), .board_id_i(MY_ID),
    .tx_pending_i(tx_pending_i), .tx_dst_i(tx_dst_i), .tx_pay_i(tx_pay_i),
    .tx_pop_o(tx_pop_o), .bus_data_i(bus_data_i), .bus_data_o(bus_data_o),
    .bus_oe_o(bus_oe_o), .busy_o(busy_o), .req_i(req_i), .gnt_o(gnt_o),
    .req_o(req_o), .gnt_i(gnt_i), .rx_valid_o(rx_valid_o), .rx_pay_o(rx_pay_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic refresh_tx();
    tx_pending_i = (tx_q.size() != 0);
    if (tx_q.size() != 0) begin
      tx_dst_i = tx_q[0][BUS_W-2 -: ID_W];
      tx_pay_i = tx_q[0][PAY_W-1:0];
    end
  endtask

  // driver: queue a local packet and the word expected on the bus
  task automatic push_pkt(input logic [ID_W-1:0] dst, input int seed);
    logic [BUS_W-1:0] w;
    w = {1'b1, dst, PAY_W'(seed) * PAY_W'(32'h9E37_79B1) + PAY_W'(seed)};
    tx_q.push_back(w);
    exp_bus.push_back(w);
    refresh_tx();
  endtask

  task automatic wait_gnt();
    while (gnt_o == '0) tick();
  endtask

  task automatic do_reset(input logic master);
    rst_ni = 1'b0;
    is_master_i = master;
    req_i = '0;
    gnt_i = 1'b0;
    bus_data_i = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    tick();
  endtask

  // monitor: pop and compare as the design produces results
  always @(negedge clk) begin
    if (rst_ni) begin
      if (bus_oe_o && bus_data_o[BUS_W-1]) begin
        chk(tx_pop_o == 1'b1, {mon_tag, " pop"}, 128'(tx_pop_o), 128'd1);
        if (exp_bus.size() == 0) begin
          chk(1'b0, {mon_tag, " unexpected word"}, 128'(bus_data_o), 128'd0);
        end else begin
          logic [BUS_W-1:0] e;
          e = exp_bus.pop_front();
          chk(bus_data_o == e, {mon_tag, " bus word"}, 128'(bus_data_o), 128'(e));
        end
        if (tx_q.size() != 0) void'(tx_q.pop_front());
        refresh_tx();
      end
      if (gnt_o != '0 && gnt_prev == '0) begin
        int idx;
        idx = -1;
        for (int k = 0; k < N; k++) if (gnt_o[k]) idx = k;
        if (exp_gnt.size() == 0) begin
          chk(1'b0, "R5 unexpected grant", 128'(idx), 128'd0);
        end else begin
          int e;
          e = exp_gnt.pop_front();
          chk(idx == e, "R5 grant order", 128'(idx), 128'(e));
        end
      end
      gnt_prev = gnt_o;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #5;
    chk({busy_o, gnt_o, req_o, bus_oe_o, tx_pop_o, rx_valid_o} == '0, "R1 in reset",
        128'({busy_o, gnt_o, req_o, bus_oe_o, tx_pop_o, rx_valid_o}), 128'd0);
    do_reset(1'b1);
    chk({busy_o, gnt_o, req_o, bus_oe_o, tx_pop_o, rx_valid_o} == '0, "R1 after reset",
        128'({busy_o, gnt_o, req_o, bus_oe_o, tx_pop_o, rx_valid_o}), 128'd0);

    // R2 single request granted next cycle
    exp_gnt.push_back(1);
    req_i = 3'b010;
    tick();
    chk(gnt_o == 3'b010 && busy_o, "R2 grant with busy", 128'({busy_o, gnt_o}), 128'({1'b1, 3'b010}));
    // R4 tenure held while request high
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(gnt_o == 3'b010 && busy_o && !bus_oe_o, "R4 hold", 128'({bus_oe_o, busy_o, gnt_o}), 128'({1'b0, 1'b1, 3'b010}));
    end
    req_i = 3'b000;
    tick();
    chk(gnt_o == '0 && !busy_o, "R4 release", 128'({busy_o, gnt_o}), 128'd0);

    // R5 rotation: pointer now at slave 2
    exp_gnt.push_back(2);
    exp_gnt.push_back(0);
    exp_gnt.push_back(1);
    req_i = 3'b111;
    for (int i = 0; i < 3; i++) begin
      wait_gnt();
      tick();
      req_i = req_i & ~gnt_o;
      tick();
    end
    tick();
    chk(exp_gnt.size() == 0, "R5 all grants seen", 128'(exp_gnt.size()), 128'd0);

    // R6 request and local traffic at once: slave wins, master waits
    exp_gnt.push_back(2);
    push_pkt(8'h11, 1);
    push_pkt(8'h22, 2);
    req_i = 3'b100;
    wait_gnt();
    for (int i = 0; i < 3; i++) begin
      chk(!bus_oe_o && !tx_pop_o, "R6 master silent under grant", 128'({bus_oe_o, tx_pop_o}), 128'd0);
      tick();
    end
    req_i = '0;
    tick();
    chk(gnt_o == '0 && !bus_oe_o, "R7 gap after grant", 128'({bus_oe_o, gnt_o}), 128'd0);
    // R9 self-driven words are not received
    bus_data_i = {1'b1, MY_ID, PAY_W'(77)};
    while (!bus_oe_o) tick();
    chk(busy_o, "R6 busy during send", 128'(busy_o), 128'd1);
    chk(!rx_valid_o, "R9 no self receive", 128'(rx_valid_o), 128'd0);
    while (busy_o) tick();
    chk(tx_q.size() == 0 && exp_bus.size() == 0, "R6 queue drained", 128'(exp_bus.size()), 128'd0);

    // R6 request during master transfer waits
    push_pkt(8'h33, 3);
    push_pkt(8'h44, 4);
    push_pkt(8'h55, 5);
    while (!bus_oe_o) tick();
    exp_gnt.push_back(0);
    req_i = 3'b001;
    while (bus_oe_o) begin
      chk(gnt_o == '0, "R6 request deferred", 128'(gnt_o), 128'd0);
      tick();
    end
    wait_gnt();
    chk(gnt_o == 3'b001 && exp_bus.size() == 0, "R6 grant after send", 128'(gnt_o), 128'b001);
    req_i = '0;
    tick();
    tick();

    // R9 receive filter
    bus_data_i = {1'b1, MY_ID, PAY_W'(123)};
    #1;
    chk(rx_valid_o && rx_pay_o == PAY_W'(123), "R9 match", 128'({rx_valid_o, rx_pay_o}), 128'({1'b1, PAY_W'(123)}));
    bus_data_i = {1'b1, 8'h06, PAY_W'(123)};
    #1;
    chk(!rx_valid_o, "R9 other board", 128'(rx_valid_o), 128'd0);
    bus_data_i = {1'b0, MY_ID, PAY_W'(123)};
    #1;
    chk(!rx_valid_o, "R9 invalid word", 128'(rx_valid_o), 128'd0);
    bus_data_i = '0;

    // slave role
    do_reset(1'b0);
    mon_tag = "R3";
    req_i = 3'b111;
    repeat (3) tick();
    chk(gnt_o == '0 && !busy_o, "R10 slave quiet", 128'({busy_o, gnt_o}), 128'd0);
    req_i = '0;
    push_pkt(8'h01, 6);
    push_pkt(8'h02, 7);
    push_pkt(8'h03, 8);
    tick();
    chk(req_o, "R3 request raised", 128'(req_o), 128'd1);
    repeat (2) begin
      tick();
      chk(!bus_oe_o, "R3 no drive before grant", 128'(bus_oe_o), 128'd0);
    end
    gnt_i = 1'b1;
    chk(!bus_oe_o, "R3 grant just seen", 128'(bus_oe_o), 128'd0);
    tick();
    chk(bus_oe_o, "R3 drive after grant", 128'(bus_oe_o), 128'd1);
    mon_tag = "R8";
    while (req_o) tick();
    chk(!bus_oe_o, "R8 drive drops with request", 128'(bus_oe_o), 128'd0);
    chk(exp_bus.size() == 0, "R8 all words sent", 128'(exp_bus.size()), 128'd0);
    tick();
    gnt_i = 1'b0;
    tick();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule